// File: doc/BRIEF.md
# PC Card host access decoder

This block sits behind the pins of a 16-bit removable-card host interface. It turns each host bus cycle into three things that the rest of the card needs. The first is which register space the cycle addresses: attribute space, task file, or nothing. The second is which task file register is meant. The third is how the even and odd bytes of that register map onto the low and high halves of the data bus. It also decides whether the card drives the data bus and whether it returns the input-acknowledge strobe that a host uses to steer its own data buffers during I/O reads.

A static mode input picks the decoding personality. In memory-mapped mode the task file is reached through the output/write enables. The three I/O personalities (contiguous, primary, secondary) reach it through the I/O read and write strobes and decode their own address windows. In the disk-drive personality the two card enables act as the two register-block chip selects, and the byte-lane rules change. All outputs are registered once, so a cycle's decode is visible one clock after it is sampled.

Top module: `hcd_access_decoder`

## Requirements
- R1: Outputs are registered. They show the decode of the inputs sampled at the previous rising clock edge, and reset forces the idle result. The idle result is space 0 (none), index 0, both lane codes 0, no drive and inpack_n high. When both card enables are high the result is idle in every mode. Space codes are 0 none, 1 attribute, 2 task file.
- R2: Lane codes are 0 off, 1 even byte, 2 odd byte. With ce1_n low and ce2_n high (byte cycle), the low lane carries the even byte when A0 is 0 and the odd byte when A0 is 1, and the high lane is off. For task file cycles, index bit 0 follows A0.
- R3: With both enables low (word cycle), the low lane carries the even byte, the high lane the odd byte, and task file index bit 0 is 0. With only ce2_n low (odd-byte cycle), only the high lane is used and carries the odd byte, and index bit 0 is 1.
- R4: In any mode other than the disk-drive one, a cycle with reg_n low that is strobed by oe_n or we_n selects attribute space with index 0.
- R5: In memory-mapped mode (mode 0), a cycle with reg_n high strobed by oe_n or we_n selects the task file only at addresses 0h-Fh or 400h-7FFh, with index A3..A0. Other addresses select nothing.
- R6: The I/O strobes select nothing in memory-mapped mode. In the I/O modes (1 to 3), the task file is reached only through iord_n or iowr_n with reg_n low. oe_n/we_n cycles with reg_n high select nothing there.
- R7: Contiguous mode (1) accepts any address, with index A3..A0. Primary mode (2) accepts 1F0h-1F7h as index 0-7 and 3F6h-3F7h as index 14-15. Secondary mode (3) accepts 170h-177h as index 0-7 and 376h-377h as index 14-15. Other addresses select nothing.
- R8: In disk-drive mode (4), reg_n, oe_n, we_n and A10..A3 are ignored. ce1_n low alone selects task file index A2..A0. ce2_n low alone selects index 14 only when A2..A0 is 6; other offsets select nothing. Both enables low selects nothing.
- R9: In disk-drive mode, index 0 is a word transfer (low lane even, high lane odd). Every other register uses only the low lane (even), with the high lane off.
- R10: inpack_n is low exactly when an I/O mode (1 to 3) decodes an iord_n read to the task file. It stays high in memory-mapped and disk-drive modes.
- R11: More than one active strobe, counting oe_n, we_n, iord_n and iowr_n (only the last two in disk-drive mode), or no active strobe, yields the idle result.
- R12: dout_en is high exactly when a read strobe (oe_n or iord_n) is decoded to a space. Whenever the space is none, both lanes are off.
- R13: Mode codes 5 to 7 are unused and always yield the idle result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Decoding personality: 0 memory, 1 contiguous I/O, 2 primary I/O, 3 secondary I/O, 4 disk-drive |
| reg_n | input | 1 | Attribute space select, active low |
| ce1_n | input | 1 | Even-byte card enable, active low |
| ce2_n | input | 1 | Odd-byte card enable, active low |
| addr_i | input | ADDR_W | Host address |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| space_o | output | 2 | Selected register space |
| tf_idx_o | output | IDX_W | Task file register index |
| lane_lo_o | output | 2 | Byte placed on the low data lane |
| lane_hi_o | output | 2 | Byte placed on the high data lane |
| dout_en_o | output | 1 | Card drives the data bus |
| inpack_n_o | output | 1 | Input acknowledge, active low |

## Verification
The decoder holds no state beyond its single output register, so any fault in the strobe classification, window compare or lane steering shows up one clock after the offending cycle. It appears as a wrong space code, a shifted index or a mis-placed lane. The reference model recomputes every output from the sampled pins each clock, so the fault cannot hide behind later cycles. Window edges (one past 1F7h, 3F5h, 3F8h) and enable-pattern changes are driven on purpose. A comparison that is one address too wide or narrow, or an index bit 0 taken from the wrong source, therefore fails on its first occurrence.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

   typedef enum logic [1:0] {
      SP_NONE = 2'd0,
      SP_ATTR = 2'd1,
      SP_TF   = 2'd2
   } space_e;

   typedef enum logic [1:0] {
      LN_OFF  = 2'd0,
      LN_EVEN = 2'd1,
      LN_ODD  = 2'd2
   } lane_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MRD,
      ST_MWR,
      ST_IORD,
      ST_IOWR,
      ST_CLASH
   } strobe_e;

   localparam logic [2:0] MODE_MEM    = 3'd0;
   localparam logic [2:0] MODE_CONTIG = 3'd1;
   localparam logic [2:0] MODE_PRI    = 3'd2;
   localparam logic [2:0] MODE_SEC    = 3'd3;
   localparam logic [2:0] MODE_IDE    = 3'd4;

endpackage

// File: rtl/hcd_strobe_class.sv
module hcd_strobe_class
   import hcd_pkg::*;
(
   input  logic    ide_i,
   input  logic    oe_n_i,
   input  logic    we_n_i,
   input  logic    iord_n_i,
   input  logic    iowr_n_i,
   output strobe_e kind_o
);

   logic [3:0] act;

   // in the disk-drive personality the memory strobes are tied off by the host
   assign act = {~oe_n_i & ~ide_i, ~we_n_i & ~ide_i, ~iord_n_i, ~iowr_n_i};

   always_comb begin
      if ($countones(act) > 1)  kind_o = ST_CLASH;
      else if (act[3])          kind_o = ST_MRD;
      else if (act[2])          kind_o = ST_MWR;
      else if (act[1])          kind_o = ST_IORD;
      else if (act[0])          kind_o = ST_IOWR;
      else                      kind_o = ST_IDLE;
   end

endmodule

// File: rtl/hcd_lane_steer.sv
module hcd_lane_steer
   import hcd_pkg::*;
(
   input  logic  ce1_n_i,
   input  logic  ce2_n_i,
   input  logic  a0_i,
   output lane_e lo_o,
   output lane_e hi_o,
   output logic  sel_o,
   output logic  bit0_o
);

   always_comb begin
      lo_o   = LN_OFF;
      hi_o   = LN_OFF;
      sel_o  = 1'b0;
      bit0_o = 1'b0;
      case ({ce2_n_i, ce1_n_i})
         2'b10: begin   // byte cycle on the low lane
            lo_o   = a0_i ? LN_ODD : LN_EVEN;
            sel_o  = 1'b1;
            bit0_o = a0_i;
         end
         2'b00: begin   // word cycle
            lo_o   = LN_EVEN;
            hi_o   = LN_ODD;
            sel_o  = 1'b1;
         end
         2'b01: begin   // odd byte on the high lane
            hi_o   = LN_ODD;
            sel_o  = 1'b1;
            bit0_o = 1'b1;
         end
         default: ;     // standby
      endcase
   end

endmodule

// File: rtl/hcd_window.sv
module hcd_window
   import hcd_pkg::*;
#(
   parameter int unsigned           ADDR_W        = 11,
   parameter int unsigned           IDX_W         = 4,
   parameter logic [ADDR_W-1:0]     PRI_BASE      = ADDR_W'(11'h1F0),
   parameter logic [ADDR_W-1:0]     PRI_ALT       = ADDR_W'(11'h3F6),
   parameter logic [ADDR_W-1:0]     SEC_BASE      = ADDR_W'(11'h170),
   parameter logic [ADDR_W-1:0]     SEC_ALT       = ADDR_W'(11'h376),
   parameter logic [ADDR_W-1:0]     MEM_LOW_TOP   = ADDR_W'(11'h010),
   parameter logic [ADDR_W-1:0]     MEM_HIGH_BASE = ADDR_W'(11'h400)
)(
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int unsigned BLK_SH = 3;  // eight-register block
   localparam int unsigned ALT_SH = 1;  // two-register alternate pair
   localparam int unsigned N_MAP  = 2;

   logic [N_MAP-1:0] blk_hit, alt_hit;

   for (genvar gi = 0; gi < N_MAP; gi++) begin : g_map
      localparam logic [ADDR_W-1:0] BASE = (gi == 0) ? PRI_BASE : SEC_BASE;
      localparam logic [ADDR_W-1:0] ALT  = (gi == 0) ? PRI_ALT  : SEC_ALT;
      assign blk_hit[gi] = addr_i[ADDR_W-1:BLK_SH] == BASE[ADDR_W-1:BLK_SH];
      assign alt_hit[gi] = addr_i[ADDR_W-1:ALT_SH] == ALT[ADDR_W-1:ALT_SH];
   end

   logic [IDX_W-1:0] lin_idx, blk_idx, alt_idx;
   assign lin_idx = addr_i[IDX_W-1:0];
   assign blk_idx = IDX_W'(addr_i[2:0]);
   assign alt_idx = IDX_W'({1'b1, addr_i[2:0]});

   always_comb begin
      hit_o = 1'b0;
      idx_o = lin_idx;
      case (mode_i)
         MODE_MEM:    hit_o = (addr_i < MEM_LOW_TOP) || (addr_i >= MEM_HIGH_BASE);
         MODE_CONTIG: hit_o = 1'b1;
         MODE_PRI: begin
            hit_o = blk_hit[0] | alt_hit[0];
            idx_o = blk_hit[0] ? blk_idx : alt_idx;
         end
         MODE_SEC: begin
            hit_o = blk_hit[1] | alt_hit[1];
            idx_o = blk_hit[1] ? blk_idx : alt_idx;
         end
         default: hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/hcd_access_decoder.sv
module hcd_access_decoder
   import hcd_pkg::*;
#(
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned IDX_W   = 4,
   parameter bit          OUT_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              reg_n,
   input  logic              ce1_n,
   input  logic              ce2_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              iord_n,
   input  logic              iowr_n,
   output logic [1:0]        space_o,
   output logic [IDX_W-1:0]  tf_idx_o,
   output logic [1:0]        lane_lo_o,
   output logic [1:0]        lane_hi_o,
   output logic              dout_en_o,
   output logic              inpack_n_o
);

   localparam logic [2:0]       IDE_ALT_OFS = 3'd6;
   localparam logic [IDX_W-1:0] ALT_IDX     = IDX_W'({1'b1, IDE_ALT_OFS});

   if (ADDR_W < 11) begin : g_bad_addr
      $error("hcd_access_decoder: ADDR_W must cover the 11-bit card address");
   end
   if (IDX_W < 4) begin : g_bad_idx
      $error("hcd_access_decoder: IDX_W must hold sixteen register indices");
   end

   logic is_ide, is_mem, is_io;
   assign is_ide = mode_i == MODE_IDE;
   assign is_mem = mode_i == MODE_MEM;
   assign is_io  = (mode_i == MODE_CONTIG) || (mode_i == MODE_PRI) || (mode_i == MODE_SEC);

   strobe_e          kind;
   lane_e            st_lo, st_hi;
   logic             st_sel, st_bit0;
   logic             win_hit;
   logic [IDX_W-1:0] win_idx;

   hcd_strobe_class u_strobe (
      .ide_i   (is_ide),
      .oe_n_i  (oe_n),
      .we_n_i  (we_n),
      .iord_n_i(iord_n),
      .iowr_n_i(iowr_n),
      .kind_o  (kind)
   );

   hcd_lane_steer u_lane (
      .ce1_n_i(ce1_n),
      .ce2_n_i(ce2_n),
      .a0_i   (addr_i[0]),
      .lo_o   (st_lo),
      .hi_o   (st_hi),
      .sel_o  (st_sel),
      .bit0_o (st_bit0)
   );

   hcd_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_win (
      .mode_i(mode_i),
      .addr_i(addr_i),
      .hit_o (win_hit),
      .idx_o (win_idx)
   );

   space_e           nx_space;
   logic [IDX_W-1:0] nx_idx;
   lane_e            nx_lo, nx_hi;
   logic             nx_drive, nx_ack, is_rd, mem_stb, io_stb;

   assign is_rd   = (kind == ST_MRD)  || (kind == ST_IORD);
   assign mem_stb = (kind == ST_MRD)  || (kind == ST_MWR);
   assign io_stb  = (kind == ST_IORD) || (kind == ST_IOWR);

   always_comb begin
      nx_space = SP_NONE;
      nx_idx   = '0;
      nx_lo    = LN_OFF;
      nx_hi    = LN_OFF;
      if (is_ide) begin
         if (io_stb) begin
            if (!ce1_n && ce2_n) begin
               nx_space = SP_TF;
               nx_idx   = IDX_W'(addr_i[2:0]);
               nx_lo    = LN_EVEN;
               nx_hi    = (addr_i[2:0] == 3'd0) ? LN_ODD : LN_OFF;
            end else if (ce1_n && !ce2_n && addr_i[2:0] == IDE_ALT_OFS) begin
               nx_space = SP_TF;
               nx_idx   = ALT_IDX;
               nx_lo    = LN_EVEN;
            end
         end
      end else if (st_sel && (is_mem || is_io)) begin
         if (mem_stb) begin
            if (!reg_n)                 nx_space = SP_ATTR;
            else if (is_mem && win_hit) nx_space = SP_TF;
         end else if (io_stb && is_io && !reg_n && win_hit) begin
            nx_space = SP_TF;
         end
         if (nx_space != SP_NONE) begin
            nx_lo = st_lo;
            nx_hi = st_hi;
         end
         if (nx_space == SP_TF) nx_idx = {win_idx[IDX_W-1:1], st_bit0};
      end
      nx_drive = (nx_space != SP_NONE) && is_rd;
      nx_ack   = (nx_space == SP_TF) && (kind == ST_IORD) && is_io;
   end

   space_e           space_q;
   logic [IDX_W-1:0] idx_q;
   lane_e            lo_q, hi_q;
   logic             drive_q, ack_q;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            space_q <= SP_NONE;
            idx_q   <= '0;
            lo_q    <= LN_OFF;
            hi_q    <= LN_OFF;
            drive_q <= 1'b0;
            ack_q   <= 1'b0;
         end else begin
            space_q <= nx_space;
            idx_q   <= nx_idx;
            lo_q    <= nx_lo;
            hi_q    <= nx_hi;
            drive_q <= nx_drive;
            ack_q   <= nx_ack;
         end
      end

      assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ce1_n && ce2_n) |-> (space_o == SP_NONE && !dout_en_o));

      assert_ack_is_tf_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !inpack_n_o |-> (space_o == SP_TF && dout_en_o));

      assert_mem_mode_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(mode_i) == MODE_MEM) |-> inpack_n_o);

      assert_none_lanes_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (space_o == SP_NONE) |-> (lane_lo_o == LN_OFF && lane_hi_o == LN_OFF && !dout_en_o));

      assert_ide_word_only_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(mode_i) == MODE_IDE && lane_hi_o == LN_ODD) |-> (tf_idx_o == '0));
   end else begin : g_comb
      assign space_q = nx_space;
      assign idx_q   = nx_idx;
      assign lo_q    = nx_lo;
      assign hi_q    = nx_hi;
      assign drive_q = nx_drive;
      assign ack_q   = nx_ack;
   end

   assign space_o    = space_q;
   assign tf_idx_o   = idx_q;
   assign lane_lo_o  = lo_q;
   assign lane_hi_o  = hi_q;
   assign dout_en_o  = drive_q;
   assign inpack_n_o = ~ack_q;

endmodule

// File: tb/sim_hcd_access_decoder.sv
`timescale 1ns/1ps
module sim_hcd_access_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode;
   logic        reg_n, ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n;
   logic [10:0] addr;
   logic [1:0]  space, lane_lo, lane_hi;
   logic [3:0]  idx;
   logic        dout_en, inpack_n;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   hcd_access_decoder u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .reg_n(reg_n),
      .ce1_n(ce1_n), .ce2_n(ce2_n), .addr_i(addr), .oe_n(oe_n), .we_n(we_n),
      .iord_n(iord_n), .iowr_n(iowr_n), .space_o(space), .tf_idx_o(idx),
      .lane_lo_o(lane_lo), .lane_hi_o(lane_hi), .dout_en_o(dout_en),
      .inpack_n_o(inpack_n)
   );

   // behavioural expectation straight from the requirement text
   function automatic void model(input int m, r, c1, c2, a, o, w, ir, iw,
                                 output int sp, ix, lo, hi, den, inp);
      int n_act;
      bit mem_s, rd;
      sp = 0; ix = 0; lo = 0; hi = 0; den = 0; inp = 1;
      if (m > 4) return;
      if (m == 4) begin
         if (ir == iw) return;
         if (c1 == 0 && c2 == 1) begin
            sp = 2; ix = a % 8; lo = 1; hi = (ix == 0) ? 2 : 0;
         end else if (c1 == 1 && c2 == 0 && a % 8 == 6) begin
            sp = 2; ix = 14; lo = 1;
         end else return;
         den = (ir == 0);
         return;
      end
      n_act = (o == 0) + (w == 0) + (ir == 0) + (iw == 0);
      if (n_act != 1 || (c1 == 1 && c2 == 1)) return;
      mem_s = (o == 0) || (w == 0);
      rd    = (o == 0) || (ir == 0);
      if (mem_s && r == 0) begin
         sp = 1;
      end else if (mem_s && m == 0 && (a < 16 || a >= 1024)) begin
         sp = 2; ix = a % 16;
      end else if (!mem_s && m != 0 && r == 0) begin
         if (m == 1) begin sp = 2; ix = a % 16; end
         else if (m == 2 && a >= 'h1F0 && a <= 'h1F7) begin sp = 2; ix = a - 'h1F0; end
         else if (m == 2 && (a == 'h3F6 || a == 'h3F7)) begin sp = 2; ix = a - 'h3F0 + 8; end
         else if (m == 3 && a >= 'h170 && a <= 'h177) begin sp = 2; ix = a - 'h170; end
         else if (m == 3 && (a == 'h376 || a == 'h377)) begin sp = 2; ix = a - 'h370 + 8; end
      end
      if (sp == 0) return;
      if (c1 == 0 && c2 == 1) lo = (a % 2 == 1) ? 2 : 1;
      else if (c1 == 0 && c2 == 0) begin lo = 1; hi = 2; end
      else hi = 2;
      if (sp == 2) begin
         if (c1 == 0 && c2 == 0) ix = ix - (ix % 2);
         else if (c1 == 1) ix = ix - (ix % 2) + 1;
      end
      den = rd;
      inp = (sp == 2 && ir == 0 && m >= 1 && m <= 3) ? 0 : 1;
   endfunction

   task automatic check(input string tag, input int esp, eix, elo, ehi, eden, einp);
      n_chk++;
      if (int'(space) != esp || int'(idx) != eix || int'(lane_lo) != elo ||
          int'(lane_hi) != ehi || int'(dout_en) != eden || int'(inpack_n) != einp) begin
         n_bad++;
         $display("FAIL %s: got sp=%0d idx=%0d lo=%0d hi=%0d den=%0d inp=%0d expected sp=%0d idx=%0d lo=%0d hi=%0d den=%0d inp=%0d",
                  tag, space, idx, lane_lo, lane_hi, dout_en, inpack_n,
                  esp, eix, elo, ehi, eden, einp);
      end
   endtask

   // called at a falling edge; result is registered at the next rising edge
   task automatic apply(input string tag, input int m, r, c1, c2, a, o, w, ir, iw);
      int esp, eix, elo, ehi, eden, einp;
      mode = m[2:0]; reg_n = r[0]; ce1_n = c1[0]; ce2_n = c2[0]; addr = a[10:0];
      oe_n = o[0]; we_n = w[0]; iord_n = ir[0]; iowr_n = iw[0];
      model(m, r, c1, c2, a, o, w, ir, iw, esp, eix, elo, ehi, eden, einp);
      @(negedge clk);
      check(tag, esp, eix, elo, ehi, eden, einp);
   endtask

   initial begin
      mode = 3'd0; reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; addr = '0;
      oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset", 0, 0, 0, 0, 0, 1);
      rst_n = 1'b1;
      @(negedge clk);
      //         tag                      m  r  c1 c2 addr    oe we ir iw
      apply("R1 standby",                0, 1, 1, 1, 'h002,  0, 1, 1, 1);
      apply("R1 standby ide",            4, 1, 1, 1, 'h000,  1, 1, 0, 1);
      apply("R2 byte even",              0, 1, 0, 1, 'h002,  0, 1, 1, 1);
      apply("R2 byte odd",               0, 1, 0, 1, 'h003,  0, 1, 1, 1);
      apply("R3 word",                   0, 1, 0, 0, 'h005,  0, 1, 1, 1);
      apply("R3 odd only",               0, 1, 1, 0, 'h004,  1, 0, 1, 1);
      apply("R4 attr write",             0, 0, 0, 1, 'h200,  1, 0, 1, 1);
      apply("R4 attr read io mode",      2, 0, 0, 0, 'h202,  0, 1, 1, 1);
      apply("R5 high window",            0, 1, 0, 1, 'h405,  0, 1, 1, 1);
      apply("R5 outside window",         0, 1, 0, 1, 'h200,  0, 1, 1, 1);
      apply("R6 io strobe in mem mode",  0, 0, 0, 1, 'h001,  1, 1, 0, 1);
      apply("R6 io strobe reg high",     2, 1, 0, 1, 'h1F0,  1, 1, 0, 1);
      apply("R6 mem strobe reg high io", 2, 1, 0, 1, 'h1F0,  0, 1, 1, 1);
      apply("R7 primary top",            2, 0, 0, 1, 'h1F7,  1, 1, 0, 1);
      apply("R7 primary alt",            2, 0, 0, 1, 'h3F6,  1, 1, 0, 1);
      apply("R7 primary past end",       2, 0, 0, 1, 'h1F8,  1, 1, 0, 1);
      apply("R7 primary below alt",      2, 0, 0, 1, 'h3F5,  1, 1, 0, 1);
      apply("R7 secondary write",        3, 0, 0, 1, 'h176,  1, 1, 1, 0);
      apply("R7 secondary alt read",     3, 0, 0, 1, 'h377,  1, 1, 0, 1);
      apply("R7 contiguous",             1, 0, 0, 1, 'h2A5,  1, 1, 0, 1);
      apply("R8 ide ce1 ignores high",   4, 0, 0, 1, 'h7FB,  0, 1, 0, 1);
      apply("R8 ide ce2 offset 6",       4, 1, 1, 0, 'h006,  1, 1, 1, 0);
      apply("R8 ide ce2 offset 5",       4, 1, 1, 0, 'h005,  1, 1, 0, 1);
      apply("R8 ide both selects",       4, 1, 0, 0, 'h001,  1, 1, 0, 1);
      apply("R9 ide data word",          4, 1, 0, 1, 'h000,  0, 0, 0, 1);
      apply("R10 ide no ack",            4, 1, 0, 1, 'h007,  1, 1, 0, 1);
      apply("R11 oe and we",             0, 1, 0, 1, 'h001,  0, 0, 1, 1);
      apply("R11 iord and oe",           2, 0, 0, 1, 'h1F0,  0, 1, 0, 1);
      apply("R11 no strobe",             1, 0, 0, 1, 'h001,  1, 1, 1, 1);
      apply("R12 write no drive",        1, 0, 0, 0, 'h00A,  1, 1, 1, 0);
      apply("R13 unused mode",           5, 0, 0, 1, 'h1F0,  1, 1, 0, 1);
      apply("R13 unused mode attr",      7, 0, 0, 1, 'h200,  0, 1, 1, 1);
      for (int i = 0; i < 400; i++) begin
         int m, a, s, o, w, ir, iw;
         m = $urandom_range(0, 6);
         case ($urandom_range(0, 5))
            0: a = $urandom_range(0, 15);
            1: a = 'h1F0 + $urandom_range(0, 8);
            2: a = 'h3F5 + $urandom_range(0, 3);
            3: a = 'h170 + $urandom_range(0, 8);
            4: a = 'h375 + $urandom_range(0, 3);
            default: a = $urandom_range(0, 2047);
         endcase
         s = $urandom_range(0, 5);
         o = (s == 0 || s == 5) ? 0 : 1;
         w = (s == 1) ? 0 : 1;
         ir = (s == 2 || s == 5) ? 0 : 1;
         iw = (s == 3) ? 0 : 1;
         apply("R12 random", m, $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), a, o, w, ir, iw);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12 watchdog: got unfinished run expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule